// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Write Port

This block accepts 16-bit command words over a three-wire serial link and routes each one into the holding registers of a two-channel DAC controller. Words are shifted in MSB first on rising edges of the serial clock while the active-low select is held low. The block samples the serial pins with its own system clock through a synchronizer, so the serial clock must stay high and low for at least three system clocks per phase. A word takes effect on the sixteenth rising serial edge. If the select is released before that, the word takes effect on the release.

Two selector bits in each word choose the route:
- A write to channel A also copies the staging register into channel B, so both outputs change in the same cycle.
- A write to channel B also writes the staging register.
- A stage-only write changes neither output.
- A control write sets the reference mode.

A one-cycle strobe per channel marks each write to that channel's output register.

Top module: `dual_dac_wr`

## Requirements
- R1: A frame is 16 rising serial-clock edges with the select low. Bits arrive MSB first. The word is decoded on the sixteenth edge, without waiting for the select to rise.
- R2: If the select rises after 1 to 15 edges, the received bits are decoded as a word. They are right-justified, so the last bit is at bit 0, and the unfilled upper bits are zero.
- R3: Selector {bit15,bit12}=2'b10 loads channel A from bits 11:0 and loads channel B from the staging register. The staging register is unchanged. Both update strobes pulse in the same clock.
- R4: Selector 2'b00 loads channel B and the staging register from bits 11:0. Channel A is unchanged. Only the B strobe pulses.
- R5: Selector 2'b01 loads only the staging register. Neither output changes and no strobe pulses. The new value appears on channel B at the next channel A write.
- R6: Selector 2'b11 is a control write. It loads the reference mode from bits 1:0. The internal-reference flag is high exactly when the mode is 2'b10. All other bits of a control word have no effect, and the channel outputs are unchanged.
- R7: Every decoded word copies its bits 14:13 to the aux output. These bits have no effect on routing.
- R8: Serial edges after the sixteenth are ignored until the select rises. Releasing the select after a complete word causes no second transfer.
- R9: Toggling the select with no serial edge in between causes no transfer.
- R10: After the asynchronous active-low reset, both channels, the staging register, the mode and the aux bits are zero, and no strobe is high.
- R11: Each update strobe is high for exactly one system clock per channel write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, sampled |
| cs_n | input | 1 | Active-low frame select, sampled |
| sdi | input | 1 | Serial data, MSB first |
| chan_a_o | output | 12 | Channel A output register |
| chan_b_o | output | 12 | Channel B output register |
| upd_a_o | output | 1 | Channel A write strobe |
| upd_b_o | output | 1 | Channel B write strobe |
| ref_mode_o | output | 2 | Reference mode field |
| ref_int_o | output | 1 | Internal reference selected |
| aux_o | output | 2 | Bits 14:13 of the last decoded word |

## Verification
The hardest state to reach is a staging register that differs from channel B, because the staging register has no port of its own. It can only be seen through the value a later channel A write copies into channel B. The random stream therefore mixes stage-only, channel B and channel A writes, so that stale and fresh staged values are both carried across by A writes. Frames cut short by an early select release, and frames padded with extra edges after the sixteenth, are also mixed into the stream. They reach the early-transfer and ignore paths.

// File: rtl/dacwr_pkg.sv
package dacwr_pkg;

   // route kind, encoded as {bit15, bit12} of the received word
   typedef enum logic [1:0] {
      XF_LOAD_B  = 2'b00,
      XF_STAGE   = 2'b01,
      XF_LOAD_A  = 2'b10,
      XF_CTRL    = 2'b11
   } xfer_e;

   function automatic xfer_e route_kind(input logic hi_sel, input logic lo_sel);
      return xfer_e'({hi_sel, lo_sel});
   endfunction

endpackage

// File: rtl/dacwr_sync.sv
module dacwr_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dacwr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] pipe_q;

   if (STAGES == 2) begin : g_two
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
         else        pipe_q <= {pipe_q[0], d};
      end
   end else begin : g_deep
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
         else        pipe_q <= {pipe_q[STAGES-2:0], d};
      end
   end

   assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/dacwr_shifter.sv
module dacwr_shifter #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              csn_s,
   input  logic              sdi_s,
   output logic              word_valid,
   output logic [WORD_W-1:0] word
);

   localparam int CNT_W = $clog2(WORD_W + 1);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

   if (WORD_W < 2) begin : g_bad_word
      $error("dacwr_shifter: WORD_W must be at least 2");
   end

   logic              sclk_prev_q;
   logic              csn_prev_q;
   logic [WORD_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              done_q;
   logic              valid_q;
   logic [WORD_W-1:0] word_q;

   logic sclk_rise;
   logic cs_rise;
   logic [WORD_W-1:0] sh_next;

   assign sclk_rise = sclk_s & ~sclk_prev_q;
   assign cs_rise   = csn_s & ~csn_prev_q;
   assign sh_next   = {sh_q[WORD_W-2:0], sdi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev_q <= 1'b0;
         csn_prev_q  <= 1'b1;
      end else begin
         sclk_prev_q <= sclk_s;
         csn_prev_q  <= csn_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         cnt_q   <= '0;
         done_q  <= 1'b0;
         valid_q <= 1'b0;
         word_q  <= '0;
      end else begin
         valid_q <= 1'b0;
         if (cs_rise) begin
            if (cnt_q != '0 && !done_q) begin
               valid_q <= 1'b1;
               word_q  <= sh_q;
            end
            sh_q   <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
         end else if (!csn_s && sclk_rise && !done_q) begin
            sh_q <= sh_next;
            if (cnt_q == LAST_IDX) begin
               valid_q <= 1'b1;
               word_q  <= sh_next;
               done_q  <= 1'b1;
               cnt_q   <= FULL_CNT;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign word_valid = valid_q;
   assign word       = word_q;

   assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL_CNT);

   assert_no_retrigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !valid_q);

   assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q);

endmodule

// File: rtl/dacwr_route.sv
module dacwr_route
   import dacwr_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int DATA_W = 12,
   parameter int AUX_W  = 2,
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_valid,
   input  logic [WORD_W-1:0] word,
   output logic [DATA_W-1:0] chan_a,
   output logic [DATA_W-1:0] chan_b,
   output logic              upd_a,
   output logic              upd_b,
   output logic [MODE_W-1:0] ref_mode,
   output logic [AUX_W-1:0]  aux
);

   localparam int SEL_HI = WORD_W - 1;
   localparam int SEL_LO = DATA_W;
   localparam int AUX_LO = DATA_W + 1;

   if (WORD_W != DATA_W + AUX_W + 2) begin : g_bad_layout
      $error("dacwr_route: WORD_W must equal DATA_W + AUX_W + 2");
   end
   if (MODE_W > DATA_W) begin : g_bad_mode
      $error("dacwr_route: MODE_W must not exceed DATA_W");
   end

   xfer_e             kind;
   logic [DATA_W-1:0] field;

   assign kind  = route_kind(word[SEL_HI], word[SEL_LO]);
   assign field = word[DATA_W-1:0];

   logic [DATA_W-1:0] a_q, b_q, stg_q;
   logic [MODE_W-1:0] mode_q;
   logic [AUX_W-1:0]  aux_q;
   logic              upd_a_q, upd_b_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q     <= '0;
         b_q     <= '0;
         stg_q   <= '0;
         mode_q  <= '0;
         aux_q   <= '0;
         upd_a_q <= 1'b0;
         upd_b_q <= 1'b0;
      end else begin
         upd_a_q <= 1'b0;
         upd_b_q <= 1'b0;
         if (word_valid) begin
            aux_q <= word[AUX_LO +: AUX_W];
            unique case (kind)
               XF_LOAD_A: begin
                  a_q     <= field;
                  b_q     <= stg_q;
                  upd_a_q <= 1'b1;
                  upd_b_q <= 1'b1;
               end
               XF_LOAD_B: begin
                  b_q     <= field;
                  stg_q   <= field;
                  upd_b_q <= 1'b1;
               end
               XF_STAGE: begin
                  stg_q <= field;
               end
               XF_CTRL: begin
                  mode_q <= field[MODE_W-1:0];
               end
               default: ;
            endcase
         end
      end
   end

   assign chan_a   = a_q;
   assign chan_b   = b_q;
   assign upd_a    = upd_a_q;
   assign upd_b    = upd_b_q;
   assign ref_mode = mode_q;
   assign aux      = aux_q;

   assert_a_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_a_q |-> $stable(a_q));

   assert_b_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_b_q |-> $stable(b_q));

   assert_pair_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      upd_a_q |-> upd_b_q);

   assert_stage_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      upd_a_q |-> $stable(stg_q));

   assert_b_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_b_q && !upd_a_q) |-> (b_q == stg_q));

   assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !word_valid |=> $stable(mode_q));

   assert_strobe_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
      upd_b_q |=> !upd_b_q);

endmodule

// File: rtl/dual_dac_wr.sv
module dual_dac_wr #(
   parameter int          WORD_W       = 16,
   parameter int          DATA_W       = 12,
   parameter int          AUX_W        = 2,
   parameter int          MODE_W       = 2,
   parameter int          SYNC_STAGES  = 2,
   parameter logic [1:0]  REF_INT_CODE = 2'b10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              sdi,
   output logic [DATA_W-1:0] chan_a_o,
   output logic [DATA_W-1:0] chan_b_o,
   output logic              upd_a_o,
   output logic              upd_b_o,
   output logic [MODE_W-1:0] ref_mode_o,
   output logic              ref_int_o,
   output logic [AUX_W-1:0]  aux_o
);

   localparam int PIN_W = 3;
   localparam logic [PIN_W-1:0] PIN_RST = 3'b010;

   if (MODE_W != 2) begin : g_bad_mode_w
      $error("dual_dac_wr: MODE_W must be 2 to match REF_INT_CODE");
   end

   logic [PIN_W-1:0]  pins_s;
   logic              word_valid;
   logic [WORD_W-1:0] word;

   dacwr_sync #(
      .W       (PIN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sdi, cs_n, sclk}),
      .q     (pins_s)
   );

   dacwr_shifter #(
      .WORD_W (WORD_W)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk_s     (pins_s[0]),
      .csn_s      (pins_s[1]),
      .sdi_s      (pins_s[2]),
      .word_valid (word_valid),
      .word       (word)
   );

   dacwr_route #(
      .WORD_W (WORD_W),
      .DATA_W (DATA_W),
      .AUX_W  (AUX_W),
      .MODE_W (MODE_W)
   ) u_route (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_valid (word_valid),
      .word       (word),
      .chan_a     (chan_a_o),
      .chan_b     (chan_b_o),
      .upd_a      (upd_a_o),
      .upd_b      (upd_b_o),
      .ref_mode   (ref_mode_o),
      .aux        (aux_o)
   );

   assign ref_int_o = (ref_mode_o == REF_INT_CODE);

endmodule

// File: tb/dual_dac_wr_bench.sv
module dual_dac_wr_bench;

   localparam int CLK_P  = 10;
   localparam int HALF_S = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        sclk, cs_n, sdi;
   logic [11:0] chan_a, chan_b;
   logic        upd_a, upd_b;
   logic [1:0]  ref_mode;
   logic        ref_int;
   logic [1:0]  aux;

   int total = 0;
   int bad   = 0;

   // reference model state
   logic [11:0] m_a = '0, m_b = '0, m_stg = '0;
   logic [1:0]  m_mode = '0, m_aux = '0;

   // strobe monitor
   int na = 0, nb = 0, nab = 0, run_a = 0, run_b = 0, run_max = 0;

   always #(CLK_P/2) clk = ~clk;

   dual_dac_wr u_dual_dac_wr (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk       (sclk),
      .cs_n       (cs_n),
      .sdi        (sdi),
      .chan_a_o   (chan_a),
      .chan_b_o   (chan_b),
      .upd_a_o    (upd_a),
      .upd_b_o    (upd_b),
      .ref_mode_o (ref_mode),
      .ref_int_o  (ref_int),
      .aux_o      (aux)
   );

   always @(negedge clk) begin
      if (upd_a) na++;
      if (upd_b) nb++;
      if (upd_a && upd_b) nab++;
      run_a = upd_a ? run_a + 1 : 0;
      run_b = upd_b ? run_b + 1 : 0;
      if (run_a > run_max) run_max = run_a;
      if (run_b > run_max) run_max = run_b;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      sclk = 1'b0;
      sdi  = b;
      wait_clk(HALF_S);
      sclk = 1'b1;
      wait_clk(HALF_S);
   endtask

   // expected received word for an n-bit frame taken from the top of w
   function automatic logic [15:0] rx_word(input logic [15:0] w, input int n);
      if (n == 0) return 16'h0;
      return w >> (16 - n);
   endfunction

   function automatic string kind_tag(input logic [15:0] rx, input int n, input int extra);
      string t;
      if (n == 0) return "R9";
      t = (n < 16) ? "R2 " : "R1 ";
      if (extra > 0) t = {t, "R8 "};
      case ({rx[15], rx[12]})
         2'b10:   t = {t, "R3"};
         2'b00:   t = {t, "R4"};
         2'b01:   t = {t, "R5"};
         default: t = {t, "R6"};
      endcase
      return t;
   endfunction

   task automatic frame(input logic [15:0] w, input int n, input int extra);
      logic [15:0] rx;
      int          ea, eb;
      string       tg;
      rx = rx_word(w, n);
      tg = kind_tag(rx, n, extra);
      ea = 0;
      eb = 0;
      na = 0; nb = 0; nab = 0; run_max = 0;
      cs_n = 1'b0;
      wait_clk(HALF_S);
      for (int i = 0; i < n; i++) send_bit(w[15-i]);
      for (int i = 0; i < extra; i++) send_bit(1'($urandom));
      sclk = 1'b0;
      wait_clk(HALF_S);
      cs_n = 1'b1;
      wait_clk(12);
      if (n > 0) begin
         m_aux = rx[14:13];
         case ({rx[15], rx[12]})
            2'b10: begin m_b = m_stg; m_a = rx[11:0]; ea = 1; eb = 1; end
            2'b00: begin m_b = rx[11:0]; m_stg = rx[11:0]; eb = 1; end
            2'b01: m_stg = rx[11:0];
            default: m_mode = rx[1:0];
         endcase
      end
      check({tg, " chan_a"}, 32'(chan_a), 32'(m_a));
      check({tg, " chan_b"}, 32'(chan_b), 32'(m_b));
      check({tg, " ref_mode"}, 32'(ref_mode), 32'(m_mode));
      check({tg, " ref_int"}, 32'(ref_int), 32'(m_mode == 2'b10));
      check({tg, " R7 aux"}, 32'(aux), 32'(m_aux));
      check({tg, " strobe A count"}, 32'(na), 32'(ea));
      check({tg, " strobe B count"}, 32'(nb), 32'(eb));
      check({tg, " R3 strobes together"}, 32'(nab), 32'(ea));
      check({tg, " R11 strobe width"}, 32'(run_max <= 1), 32'd1);
   endtask

   initial begin
      #(CLK_P * 190000);
      bad++;
      total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int unsigned seed;
      logic [15:0] w;
      int          n, ex, sel;
      seed = 32'd20240611;
      void'($urandom(seed));
      rst_n = 1'b0;
      sclk  = 1'b0;
      cs_n  = 1'b1;
      sdi   = 1'b0;
      wait_clk(5);
      // R10 reset state
      check("R10 chan_a", 32'(chan_a), 32'd0);
      check("R10 chan_b", 32'(chan_b), 32'd0);
      check("R10 ref_mode", 32'(ref_mode), 32'd0);
      check("R10 aux", 32'(aux), 32'd0);
      check("R10 strobes", 32'({upd_a, upd_b}), 32'd0);
      rst_n = 1'b1;
      wait_clk(4);

      // directed corner cases
      frame(16'h0000, 0, 0);          // R9 select toggle, no edges
      frame(16'h0ABC, 16, 0);         // R4 B and staging
      frame(16'h1123, 16, 0);         // R5 staging only
      frame(16'h8456, 16, 0);         // R3 A write pulls staged 123 into B
      frame(16'h8789, 16, 0);         // R3 repeat A write, B unchanged
      frame(16'h9002, 16, 0);         // R6 internal reference
      frame(16'hFFFD, 16, 0);         // R6 don't-care bits set, mode 01
      frame(16'h6ABC, 16, 0);         // R7 aux bits with a B write
      frame(16'h1555, 16, 0);         // R5 stage again
      frame(16'h8111, 16, 5);         // R8 extra edges after the sixteenth
      frame(16'hFFFF, 8, 0);          // R2 short frame -> B write of 0x0FF
      frame(16'hA5A5, 3, 0);          // R2 very short frame

      // constrained random mix
      for (int k = 0; k < 250; k++) begin
         w   = 16'($urandom);
         sel = int'($urandom % 4);
         w[15] = sel[1];
         w[12] = sel[0];
         n  = 16;
         ex = 0;
         case ($urandom % 8)
            0: n  = 1 + int'($urandom % 15);
            1: ex = 1 + int'($urandom % 6);
            default: ;
         endcase
         frame(w, n, ex);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule